// File: doc/BRIEF.md
# Selectable Half-Band Interpolation Chain

This block sits between a sample memory and a DAC. It raises the rate of a 16-bit signed sample stream by 2, 4 or 8, or passes the stream straight through. The whole chain runs on the DAC-rate clock. It asks for one base-rate sample every 1, 2, 4 or 8 clocks, and it drives a new output sample on every clock. Up to three identical interpolate-by-2 stages are cascaded. The rate selection sets how many of them are in the path.

Each stage is an 11-tap symmetric half-band low-pass filter applied to its input after a zero has been inserted between each pair of samples. The stage has a gain of two. Every even-offset tap except the centre is zero, so each pair of outputs splits into two parts. The first output is an original sample, delayed. The second is a six-term weighted sum that is rounded and saturated back to 16 bits.

If a sample is missing at its slot, the filters keep their state and a run of zero output samples takes the place of that sample's group. Changing the rate selection flushes the chain.

Top module: `hb_interp_chain`

## Requirements
- R1: `rate_sel` selects the rate. 0 is bypass (factor 1), 1 is x2, 2 is x4 and 3 is x8, using 1, 2 or 3 cascaded stages. `out_smp` carries a new sample on every clock, so each accepted input produces exactly factor-many outputs.
- R2: When `rate_sel` is stable, `in_ready` is high on exactly one clock out of every factor clocks. The first such clock is the first one after a flush. A sample is taken only on a clock where both `in_ready` and `in_valid` are high. `in_valid` on any other clock has no effect on the output.
- R3: In bypass, a sample accepted on one clock appears unchanged on `out_smp` during the next clock.
- R4: In each stage, the first output of the pair produced for input m is input m-3 of that stage, unchanged (this is the centre-tap branch, with tap value 0.5 and stage gain 2).
- R5: In each stage, the second output of the pair for input m is round-half-up of (20000·(x[m-2]+x[m-3]) − 4400·(x[m-1]+x[m-4]) + 784·(x[m]+x[m-5])) / 32768. This is the 11-tap filter in 16 fractional bits, with taps 784, 0, −4400, 0, 20000, 32768, 20000, 0, −4400, 0, 784, scaled by the stage gain of 2. Filter history starts at zero.
- R6: Each stage's computed value saturates to the range −32768..32767 instead of wrapping.
- R7: With a constant input level, every factor settles to exactly that level on every output.
- R8: With N stages active (N≥1), the first output of the group for a sample accepted at the end of cycle 0 after a flush appears in cycle N. In bypass it appears in cycle 1. Before that, the output is zero.
- R9: A slot where `in_ready` is high but `in_valid` is low leaves every filter's history unchanged and yields a full group of zero output samples, in the position that sample's group would have had.
- R10: A change of `rate_sel` takes one flush clock, during which `in_ready` is low. The flush clears all filter state and restarts the phase, so the next clock has `in_ready` high and a zero output.
- R11: After reset, the block is in bypass with cleared state: `out_smp` is zero and `in_ready` is high while `rate_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DAC-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Rate selection: 0 bypass, 1 x2, 2 x4, 3 x8 |
| in_smp | input | 16 | Base-rate sample, two's complement |
| in_valid | input | 1 | Upstream has a sample this clock |
| in_ready | output | 1 | Chain takes a sample this clock |
| out_smp | output | 16 | Output sample, one per clock, two's complement |

## Verification
A corrupted history word in any stage shows at the ports within one base-rate period. It appears on the interpolated sample of the next pair, and three inputs later it also appears on the delayed sample. A stuck or skewed phase counter moves `in_ready` off its single slot per period, and a downstream stage then samples the wrong half of its neighbour's pair. The first mismatch is visible within one factor-length group. A live flag that fails to clear on a gap, or a flush that leaves state behind, shows as non-zero samples where the reference expects zeros, starting at the latency given in R8.

// File: rtl/hbi_pkg.sv
`timescale 1ns/1ps
package hbi_pkg;

  localparam int SMP_W   = 16;
  localparam int FRAC_W  = 16;
  localparam int ACC_W   = 40;
  localparam int SMP_MAX = (1 << (SMP_W - 1)) - 1;
  localparam int SMP_MIN = -(1 << (SMP_W - 1));

  // non-zero side taps of the half-band filter, Q16, stage gain 2 applied at rounding
  localparam int TAP_NEAR = 20000;
  localparam int TAP_MID  = -4400;
  localparam int TAP_FAR  = 784;

  typedef logic signed [SMP_W-1:0] smp_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  // weighted sum of the six-sample window, w0 newest
  function automatic acc_t hb_mac(input smp_t w0, input smp_t w1, input smp_t w2,
                                  input smp_t w3, input smp_t w4, input smp_t w5);
    acc_t s_near, s_mid, s_far;
    s_near = acc_t'(w2) + acc_t'(w3);
    s_mid  = acc_t'(w1) + acc_t'(w4);
    s_far  = acc_t'(w0) + acc_t'(w5);
    return s_near * acc_t'(TAP_NEAR) + s_mid * acc_t'(TAP_MID) + s_far * acc_t'(TAP_FAR);
  endfunction

  // divide by 2^(FRAC_W-1) with round-half-up, then clamp to the sample range
  function automatic smp_t round_sat(input acc_t acc);
    acc_t r;
    smp_t res;
    r = (acc + (acc_t'(1) <<< (FRAC_W - 2))) >>> (FRAC_W - 1);
    if (r > acc_t'(SMP_MAX))      res = smp_t'(SMP_MAX);
    else if (r < acc_t'(SMP_MIN)) res = smp_t'(SMP_MIN);
    else                          res = smp_t'(r);
    return res;
  endfunction

endpackage

// File: rtl/hbi_sched.sv
`timescale 1ns/1ps
module hbi_sched #(
  parameter int MAX_ST = 3,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] rate_sel,
  output logic [MODE_W-1:0] act_rate,
  output logic              flush,
  output logic              take,
  output logic [MAX_ST-1:0] st_en,
  output logic [MAX_ST-1:0] st_selb
);

  localparam int PH_W = MAX_ST;

  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] ph_mask;

  assign flush   = (rate_sel != act_rate);
  assign ph_mask = PH_W'((1 << act_rate) - 1);
  assign take    = !flush && (ph == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_rate <= '0;
      ph       <= '0;
    end else if (flush) begin
      act_rate <= rate_sel;
      ph       <= '0;
    end else begin
      ph <= (ph + 1'b1) & ph_mask;
    end
  end

  // stage i samples upstream i clocks into each of its own periods,
  // and shows the second half of its pair in the back half of the period
  for (genvar i = 0; i < MAX_ST; i++) begin : g_slot
    logic [PH_W-1:0] sub_mask;
    logic [PH_W-1:0] lag_in;
    logic [PH_W-1:0] lag_out;
    assign sub_mask   = ph_mask >> i;
    assign lag_in     = (ph - PH_W'(i)) & sub_mask;
    assign lag_out    = (ph - PH_W'(i + 1)) & sub_mask;
    assign st_en[i]   = !flush && (act_rate > MODE_W'(i)) && (lag_in == '0);
    assign st_selb[i] = (lag_out > (sub_mask >> 1));
  end

  a_r2_ready_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (take && act_rate != '0) |=> !take);

  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (take || flush));

endmodule

// File: rtl/hbi_stage.sv
`timescale 1ns/1ps
module hbi_stage
  import hbi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic in_live,
  input  smp_t in_smp,
  input  logic selb,
  output smp_t out_smp,
  output logic out_live
);

  localparam int HIST_N = 5;

  smp_t hist [0:HIST_N-1];
  smp_t pair_a;
  smp_t pair_b;
  smp_t interp;
  logic live_q;
  logic accept;
  logic flat_win;

  assign accept   = en && in_live;
  assign interp   = round_sat(hb_mac(in_smp, hist[0], hist[1], hist[2], hist[3], hist[4]));
  assign flat_win = (in_smp == hist[0]) && (hist[0] == hist[1]) && (hist[1] == hist[2]) &&
                    (hist[2] == hist[3]) && (hist[3] == hist[4]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < HIST_N; k++) hist[k] <= '0;
      pair_a <= '0;
      pair_b <= '0;
      live_q <= 1'b0;
    end else if (clr) begin
      for (int k = 0; k < HIST_N; k++) hist[k] <= '0;
      pair_a <= '0;
      pair_b <= '0;
      live_q <= 1'b0;
    end else if (en) begin
      live_q <= in_live;
      if (in_live) begin
        hist[0] <= in_smp;
        for (int k = 1; k < HIST_N; k++) hist[k] <= hist[k-1];
        pair_a <= hist[2];
        pair_b <= interp;
      end
    end
  end

  assign out_live = live_q;
  assign out_smp  = live_q ? (selb ? pair_b : pair_a) : '0;

  a_r9_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !accept) |=> ($stable(hist[0]) && $stable(hist[4]) && $stable(pair_b)));

  a_r7_dc_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && accept && flat_win) |=> (pair_a == $past(in_smp) && pair_b == $past(in_smp)));

endmodule

// File: rtl/hb_interp_chain.sv
`timescale 1ns/1ps
module hb_interp_chain
  import hbi_pkg::*;
#(
  parameter int MAX_ST = 3,
  parameter int MODE_W = $clog2(MAX_ST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] rate_sel,
  input  logic [SMP_W-1:0]  in_smp,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [SMP_W-1:0]  out_smp
);

  logic [MODE_W-1:0] act_rate;
  logic              flush;
  logic              take;
  logic [MAX_ST-1:0] st_en;
  logic [MAX_ST-1:0] st_selb;

  hbi_sched #(.MAX_ST(MAX_ST), .MODE_W(MODE_W)) sched_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .act_rate (act_rate),
    .flush    (flush),
    .take     (take),
    .st_en    (st_en),
    .st_selb  (st_selb)
  );

  assign in_ready = take;

  smp_t chain_smp  [0:MAX_ST];
  logic chain_live [0:MAX_ST];

  assign chain_smp[0]  = smp_t'(in_smp);
  assign chain_live[0] = in_valid;

  for (genvar i = 0; i < MAX_ST; i++) begin : g_stage
    hbi_stage stage_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (flush),
      .en       (st_en[i]),
      .in_live  (chain_live[i]),
      .in_smp   (chain_smp[i]),
      .selb     (st_selb[i]),
      .out_smp  (chain_smp[i+1]),
      .out_live (chain_live[i+1])
    );
  end

  // bypass path: a single register
  smp_t byp_q;
  logic byp_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q    <= '0;
      byp_live <= 1'b0;
    end else if (flush) begin
      byp_q    <= '0;
      byp_live <= 1'b0;
    end else if (take && act_rate == '0) begin
      byp_q    <= smp_t'(in_smp);
      byp_live <= in_valid;
    end
  end

  always_comb begin
    if (act_rate == '0) out_smp = byp_live ? byp_q : '0;
    else                out_smp = chain_live[act_rate] ? chain_smp[act_rate] : '0;
  end

  a_r10_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (out_smp == '0));

  a_r3_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (take && act_rate == '0 && in_valid) |=> (out_smp == $past(in_smp)));

endmodule

// File: tb/hb_interp_chain_tb_top.sv
`timescale 1ns/1ps
module hb_interp_chain_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rate_sel = 2'd0;
  logic [15:0] in_smp = 16'd0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] out_smp;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int q_v[$];
  bit q_l[$];
  int src_v[$];
  bit src_l[$];

  always #10 clk = ~clk;

  hb_interp_chain dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .in_smp   (in_smp),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_smp  (out_smp)
  );

  // 11-tap filter in Q16, centre at index 5
  function automatic int tap(int k);
    case (k)
      5:       return 32768;
      4, 6:    return 20000;
      2, 8:    return -4400;
      0, 10:   return 784;
      default: return 0;
    endcase
  endfunction

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  task automatic check(string tag, int act, int expv, int tol);
    checks++;
    if (act - expv > tol || expv - act > tol) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // one stage as a direct convolution of the zero-stuffed stream (R4 R5 R6 R9)
  task automatic ref_stage();
    int xs[$];
    int nv[$];
    bit nl[$];
    xs = '{0, 0, 0, 0, 0};
    for (int j = 0; j < q_v.size(); j++) begin
      if (!q_l[j]) begin
        nv.push_back(0); nl.push_back(1'b0);
        nv.push_back(0); nl.push_back(1'b0);
      end else begin
        xs.push_back(q_v[j]);
        for (int h = 0; h < 2; h++) begin
          longint acc = 0;
          int n = 2 * (xs.size() - 1) - 1 + h;
          for (int k = 0; k <= 10; k++) begin
            int idx = n - k;
            if (idx >= 0 && idx % 2 == 0) acc += longint'(tap(k)) * longint'(xs[idx/2]);
          end
          nv.push_back(sat16((2 * acc + 32768) >>> 16));
          nl.push_back(1'b1);
        end
      end
    end
    q_v = nv;
    q_l = nl;
  endtask

  // kind: 0 random, 1 constant level, 2 saturating pattern, 3 random with gaps, 4 impulse
  task automatic run_test(int m, string tag, int nper, int kind, int level);
    int fac = 1 << m;
    int lat = (m == 0) ? 1 : m;
    int ev[$];
    int total;
    src_v = {};
    src_l = {};
    for (int p = 0; p < nper; p++) begin
      int v = int'($urandom_range(0, 65535)) - 32768;
      bit l = 1'b1;
      case (kind)
        1: v = level;
        2: v = (p % 6 == 1 || p % 6 == 4) ? -32768 : 32767;
        3: l = ($urandom_range(0, 3) != 0);
        4: v = (p == 2) ? level : 0;
        default: ;
      endcase
      src_v.push_back(v);
      src_l.push_back(l);
    end
    q_v = src_v;
    q_l = src_l;
    for (int s = 0; s < m; s++) ref_stage();
    for (int j = 0; j < q_v.size(); j++) ev.push_back(q_l[j] ? q_v[j] : 0);
    total = nper * fac + lat + 4;

    @(negedge clk);
    in_valid = 1'b0;
    rate_sel = 2'(m ^ 1);
    @(negedge clk);
    rate_sel = 2'(m);
    for (int c = 0; c < total; c++) begin
      int e;
      @(negedge clk);
      e = (c < lat) ? 0 : ((c - lat < ev.size()) ? ev[c - lat] : 0);
      check(tag, int'($signed(out_smp)), e, 1);
      if (c == 0) check("R10", int'($signed(out_smp)), 0, 0);
      if (c == lat - 1) check("R8", int'($signed(out_smp)), 0, 0);
      check((c == 0) ? "R10" : "R2", int'(in_ready), (c % fac == 0) ? 1 : 0, 0);
      if (kind == 1 && c == lat + nper * fac - 1) check("R7", int'($signed(out_smp)), level, 1);
      if (c % fac == 0) begin
        if (c / fac < nper) begin
          in_valid = src_l[c / fac];
          in_smp   = 16'(src_v[c / fac]);
        end else begin
          in_valid = 1'b0;
          in_smp   = 16'($urandom);
        end
      end else begin
        in_valid = 1'b1;             // not ready here: must be ignored (R2)
        in_smp   = 16'($urandom);
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11", int'(out_smp), 0, 0);
    check("R11", int'(in_ready), 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", int'(out_smp), 0, 0);

    run_test(0, "R3", 40, 0, 0);
    run_test(1, "R5", 30, 0, 0);
    run_test(2, "R5", 30, 0, 0);
    run_test(3, "R1", 30, 0, 0);
    run_test(1, "R4", 12, 4, 12000);
    run_test(3, "R8", 12, 4, -9000);
    run_test(1, "R7", 30, 1, -12345);
    run_test(2, "R7", 30, 1, 23456);
    run_test(3, "R7", 30, 1, -32768);
    run_test(1, "R6", 36, 2, 0);
    run_test(3, "R6", 24, 2, 0);
    run_test(0, "R9", 40, 3, 0);
    run_test(2, "R9", 30, 3, 0);
    run_test(3, "R9", 30, 3, 0);
    run_test(1, "R10", 10, 0, 0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

endmodule